// File: doc/BRIEF.md
# Atomic Swap and Compare-Swap Unit

This block holds a small byte-addressed memory and serves one kind of request: an atomic exchange. Each accepted request reads the current contents at an address and returns them. An unconditional swap always replaces those contents with the request data. A compare-swap replaces them only when they equal a supplied compare value. Either way the caller receives the old value, so software can tell whether a compare-swap took effect by comparing the returned data with its own compare value.

Requests carry a command, a byte address, a byte count, write data, a compare value and an inhibit bit. When inhibit is set, some other agent owns the access: the unit leaves memory alone and sends no response. Any accepted request that is not inhibited gets exactly one response, one cycle later, which either reports the old data or signals an error. An update made by one request is seen by a request issued in the very next cycle.

Control is a small state machine whose state register records the outcome of the previous cycle's request. The states are:

- `ST_IDLE`: no response this cycle.
- `ST_SWAP_DONE`: a swap was committed.
- `ST_CAS_HIT`: a compare matched and was committed.
- `ST_CAS_MISS`: a compare did not match, so nothing was written.
- `ST_FAULT`: the request was rejected.

Every state can move to every other state. The next state depends only on the request present in the current cycle:

- no request, or an inhibited request, leads to `ST_IDLE`;
- an illegal request leads to `ST_FAULT`;
- a legal swap leads to `ST_SWAP_DONE`;
- a legal compare-swap leads to `ST_CAS_HIT` or `ST_CAS_MISS`.

Top module: `atom_swap_unit`

## Requirements
- R1: A legal request returns the old contents of `req_size` bytes starting at `req_addr`. The data is little-endian: the byte at `req_addr` sits in `rsp_data[7:0]`. All bits above `8*req_size` are zero.
- R2: A legal swap (`req_cmd`=0) writes the low `req_size` bytes of `req_wdata` into memory. A request in the next cycle sees the new bytes.
- R3: A legal compare-swap (`req_cmd`=1) whose old value equals the compare value writes the new data and returns the old value.
- R4: A legal compare-swap whose old value differs from the compare value returns the old value and leaves memory unchanged.
- R5: For a 4-byte compare-swap, only `req_cmp[31:0]` takes part in the comparison. For an 8-byte compare-swap, all 64 bits take part.
- R6: A compare-swap with a size other than 4 or 8 responds with `rsp_err`=1 and writes nothing.
- R7: A request with `req_inhibit`=1 produces no response in the next cycle and leaves memory unchanged.
- R8: A request with `req_addr + req_size > 256` responds with `rsp_err`=1 and writes nothing.
- R9: A request whose size is not 1, 2, 4 or 8, or whose address is not a multiple of its size, responds with `rsp_err`=1 and writes nothing.
- R10: `rsp_valid` rises exactly one cycle after each accepted request that is not inhibited. It is low in the cycle after a cycle with no request. An error response carries `rsp_data`=0.
- R11: After reset, all memory bytes read as zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 1 | 0 = swap, 1 = compare-swap |
| req_addr | input | 9 | Byte address (values of 256 and above are out of range) |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | New data, little-endian |
| req_cmp | input | 64 | Compare value for compare-swap |
| req_inhibit | input | 1 | Suppress the access and its response |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Old memory contents, zero-extended |
| rsp_err | output | 1 | Request rejected |

## Verification
A wrong outcome state shows up in the cycle right after the request, as a misplaced or missing `rsp_valid` or a wrong `rsp_err`. A wrong or missing memory write stays hidden until the same bytes are exchanged again. For that reason, every write in the tests is followed by a later request to the same address, and the returned data is compared with an independently kept byte image. Requests that must not write are checked the same way. A compare-swap that wrongly hits or misses is caught in two places: in its own returned state and in the data returned by the follow-up request.

// File: rtl/atom_pkg.sv
package atom_pkg;

    typedef enum logic {
        CMD_SWAP = 1'b0,
        CMD_CAS  = 1'b1
    } atom_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWAP_DONE,
        ST_CAS_HIT,
        ST_CAS_MISS,
        ST_FAULT
    } atom_state_e;

endpackage

// File: rtl/atom_req_check.sv
module atom_req_check #(
    parameter int MEM_BYTES  = 256,
    parameter int ADDR_W     = 9,
    parameter int DATA_BYTES = 8,
    parameter int SIZE_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              legal,
    output logic              cas_size_ok
);
    logic [SIZE_W-1:0] size_m1;
    logic              size_ok;
    logic              aligned;
    logic              in_range;

    assign size_m1 = size - SIZE_W'(1);

    // legal sizes are non-zero powers of two no wider than the data path (R9)
    assign size_ok  = (size != '0) && ((size & size_m1) == '0)
                    && (32'(size) <= DATA_BYTES);

    // natural alignment: address low bits under the size mask are zero (R9)
    assign aligned  = (addr[SIZE_W-1:0] & size_m1) == '0;

    // the last byte touched must still fall inside the memory (R8)
    assign in_range = (32'(addr) + 32'(size)) <= MEM_BYTES;

    assign legal       = size_ok && aligned && in_range;

    // compare-swap is defined only for the full and half data widths (R6)
    assign cas_size_ok = (32'(size) == DATA_BYTES) || (32'(size) == DATA_BYTES / 2);
endmodule

// File: rtl/atom_byte_store.sv
module atom_byte_store #(
    parameter int MEM_BYTES  = 256,
    parameter int DATA_BYTES = 8,
    parameter int SIZE_W     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(MEM_BYTES)-1:0] base,
    input  logic [SIZE_W-1:0]       size,
    input  logic                    wr_en,
    input  logic [8*DATA_BYTES-1:0] wdata,
    output logic [8*DATA_BYTES-1:0] rd_word
);
    localparam int IDX_W = $clog2(MEM_BYTES);

    logic [7:0]       mem [MEM_BYTES];
    logic [IDX_W-1:0] lane_idx [DATA_BYTES];
    logic [DATA_BYTES-1:0] lane_on;

    // lane i covers byte base+i; lanes at or beyond the size are idle (R1)
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign lane_idx[i] = base + IDX_W'(i);
        assign lane_on[i]  = 32'(size) > i;
        assign rd_word[8*i +: 8] = lane_on[i] ? mem[lane_idx[i]] : 8'h00;
    end

    // memory clears on reset (R11); active lanes are written on wr_en (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < MEM_BYTES; j++) begin
                mem[j] <= 8'h00;
            end
        end else if (wr_en) begin
            for (int i = 0; i < DATA_BYTES; i++) begin
                if (lane_on[i]) begin
                    mem[lane_idx[i]] <= wdata[8*i +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/atom_compare.sv
module atom_compare #(
    parameter int DATA_BYTES = 8,
    parameter int SIZE_W     = 4
) (
    input  logic [8*DATA_BYTES-1:0] old_word,
    input  logic [8*DATA_BYTES-1:0] cmp_word,
    input  logic [SIZE_W-1:0]       size,
    output logic                    equal
);
    logic [8*DATA_BYTES-1:0] mask;

    // only bytes inside the access size take part (R5)
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_mask
        assign mask[8*i +: 8] = (32'(size) > i) ? 8'hFF : 8'h00;
    end

    assign equal = ((old_word ^ cmp_word) & mask) == '0;
endmodule

// File: rtl/atom_swap_unit.sv
module atom_swap_unit
    import atom_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int ADDR_W     = 9,
    parameter int DATA_BYTES = 8,
    parameter int SIZE_W     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_cmd,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [SIZE_W-1:0]       req_size,
    input  logic [8*DATA_BYTES-1:0] req_wdata,
    input  logic [8*DATA_BYTES-1:0] req_cmp,
    input  logic                    req_inhibit,
    output logic                    rsp_valid,
    output logic [8*DATA_BYTES-1:0] rsp_data,
    output logic                    rsp_err
);
    localparam int DATA_W = 8 * DATA_BYTES;
    localparam int IDX_W  = $clog2(MEM_BYTES);

    atom_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic [DATA_W-1:0] old_word;
    logic              legal, cas_size_ok, cmp_equal, wr_en, accept;
    atom_cmd_e         cmd;

    assign cmd    = atom_cmd_e'(req_cmd);
    assign accept = req_valid && !req_inhibit;

    atom_req_check #(
        .MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W),
        .DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)
    ) u_check (
        .addr(req_addr), .size(req_size),
        .legal(legal), .cas_size_ok(cas_size_ok)
    );

    atom_byte_store #(
        .MEM_BYTES(MEM_BYTES), .DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .base(req_addr[IDX_W-1:0]), .size(req_size),
        .wr_en(wr_en), .wdata(req_wdata), .rd_word(old_word)
    );

    atom_compare #(
        .DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)
    ) u_cmp (
        .old_word(old_word), .cmp_word(req_cmp),
        .size(req_size), .equal(cmp_equal)
    );

    // classify the current request into the next outcome state
    always_comb begin
        state_d = ST_IDLE;
        data_d  = '0;
        wr_en   = 1'b0;
        if (accept) begin
            unique case (cmd)
                CMD_SWAP: begin
                    if (legal) begin
                        state_d = ST_SWAP_DONE;
                        data_d  = old_word;
                        wr_en   = 1'b1;
                    end else begin
                        state_d = ST_FAULT;
                    end
                end
                CMD_CAS: begin
                    if (legal && cas_size_ok) begin
                        data_d = old_word;
                        if (cmp_equal) begin
                            state_d = ST_CAS_HIT;
                            wr_en   = 1'b1;
                        end else begin
                            state_d = ST_CAS_MISS;
                        end
                    end else begin
                        state_d = ST_FAULT;
                    end
                end
            endcase
        end
    end

    // state register with captured old data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    // outputs decoded from the outcome state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SWAP_DONE, ST_CAS_HIT, ST_CAS_MISS: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_inhibit) |=> rsp_valid); // R10
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_inhibit) |=> !rsp_valid); // R7
    AST_CAS_SIZE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_cmd && !(32'(req_size) == DATA_BYTES || 32'(req_size) == DATA_BYTES / 2))
        |=> rsp_err); // R6
    AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (32'(req_addr) + 32'(req_size) > MEM_BYTES)) |=> rsp_err); // R8
    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && 32'(req_size) == DATA_BYTES / 2)
        |=> rsp_data[DATA_W-1:DATA_W/2] == '0); // R1
    AST_WRITE_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (legal && req_valid && !req_inhibit)); // R9
endmodule

// File: tb/atom_swap_unit_bench.sv
`timescale 1ns/1ps
module atom_swap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_cmd = 1'b0;
    logic [8:0]  req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_cmp = '0;
    logic        req_inhibit = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #4 clk = ~clk;

    atom_swap_unit u_atom_swap_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_cmp(req_cmp), .req_inhibit(req_inhibit),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal_f(input logic cmd, input int addr, input int size);
        bit ok;
        ok = (size == 1 || size == 2 || size == 4 || size == 8);
        ok = ok && (addr % size == 0) && (addr + size <= 256);
        if (cmd) ok = ok && (size == 4 || size == 8);
        return ok;
    endfunction

    // expected result of a request, computed from the byte image
    task automatic expect_of(input logic cmd, input int addr, input int size,
                             input logic [63:0] cmp, output bit lg, output logic [63:0] old,
                             output bit hit);
        logic [63:0] m;
        lg = (size > 0) ? legal_f(cmd, addr, size) : 1'b0;
        old = '0;
        m = '0;
        if (lg) begin
            for (int i = 0; i < size; i++) begin
                old[8*i +: 8] = model[addr + i];
                m[8*i +: 8] = 8'hFF;
            end
        end
        hit = !cmd || (((old ^ cmp) & m) == '0);
    endtask

    task automatic commit(input int addr, input int size, input logic [63:0] wd);
        for (int i = 0; i < size; i++) model[addr + i] = wd[8*i +: 8];
    endtask

    task automatic drive(input logic cmd, input int addr, input int size,
                         input logic [63:0] wd, input logic [63:0] cmp, input logic inh);
        req_valid = 1'b1; req_cmd = cmd; req_addr = 9'(addr); req_size = 4'(size);
        req_wdata = wd; req_cmp = cmp; req_inhibit = inh;
    endtask

    task automatic issue(input logic cmd, input int addr, input int size,
                         input logic [63:0] wd, input logic [63:0] cmp, input logic inh,
                         input string tag);
        bit lg, hit;
        logic [63:0] old;
        expect_of(cmd, addr, size, cmp, lg, old, hit);
        @(negedge clk);
        drive(cmd, addr, size, wd, cmp, inh);
        @(negedge clk);
        req_valid = 1'b0;
        req_inhibit = 1'b0;
        if (inh) begin
            check(rsp_valid == 1'b0, {tag, " valid"}, 64'(rsp_valid), 64'd0);
        end else begin
            check(rsp_valid == 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'd1);
            check(rsp_err == !lg, {tag, " err"}, 64'(rsp_err), 64'(!lg));
            check(rsp_data == (lg ? old : 64'd0), {tag, " data"}, rsp_data, lg ? old : 64'd0);
            if (lg && hit) commit(addr, size, wd);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 no response after reset", 64'(rsp_valid), 64'd0);
        issue(1'b0, 0, 8, 64'h0123_4567_89AB_CDEF, '0, 1'b0, "R11 memory zero at reset");
        issue(1'b0, 248, 8, 64'h1111_2222_3333_4444, '0, 1'b0, "R11 top bytes zero");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 idle cycle silent", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_swap_basic;
        issue(1'b0, 8, 8, 64'hDEAD_BEEF_CAFE_F00D, '0, 1'b0, "R2 swap write");
        issue(1'b0, 8, 8, 64'h0, '0, 1'b0, "R1 swap returns prior");
        issue(1'b0, 3, 1, 64'hFFFF_FFFF_FFFF_FFA5, '0, 1'b0, "R2 byte swap");
        issue(1'b0, 2, 2, 64'hFFFF_FFFF_FFFF_7E7E, '0, 1'b0, "R1 half swap returns a5 high");
        issue(1'b0, 0, 8, 64'h0, '0, 1'b0, "R1 upper bytes zero extended");
    endtask

    task automatic t_little_endian;
        issue(1'b0, 16, 8, 64'h8877_6655_4433_2211, '0, 1'b0, "R2 fill lane pattern");
        issue(1'b0, 17, 1, 64'h0, '0, 1'b0, "R1 byte 17 is 22");
        issue(1'b0, 20, 4, 64'h0, '0, 1'b0, "R1 word 20 is 88776655");
        issue(1'b0, 16, 8, 64'h0, '0, 1'b0, "R1 full readback");
    endtask

    task automatic t_cas_full;
        issue(1'b0, 32, 8, 64'hAAAA_BBBB_CCCC_DDDD, '0, 1'b0, "R2 cas setup");
        issue(1'b1, 32, 8, 64'h1234_5678_9ABC_DEF0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, "R3 cas hit");
        issue(1'b1, 32, 8, 64'h5555_5555_5555_5555, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, "R4 cas miss");
        issue(1'b1, 32, 8, 64'h0, 64'h0234_5678_9ABC_DEF0, 1'b0, "R5 cas 8 upper bit differs");
        issue(1'b0, 32, 8, 64'h0, '0, 1'b0, "R4 miss left memory");
    endtask

    task automatic t_cas_narrow;
        issue(1'b0, 40, 4, 64'h0000_0000_CAFE_BABE, '0, 1'b0, "R2 narrow setup");
        issue(1'b1, 40, 4, 64'h0000_0000_0BAD_F00D, 64'hFFFF_FFFF_CAFE_BABE, 1'b0, "R5 cas 4 ignores upper cmp");
        issue(1'b1, 40, 4, 64'h0000_0000_1111_1111, 64'h0000_0000_0BAD_F00E, 1'b0, "R4 cas 4 miss");
        issue(1'b0, 40, 4, 64'h0, '0, 1'b0, "R3 narrow commit visible");
        issue(1'b0, 44, 4, 64'h0, '0, 1'b0, "R5 neighbour word untouched");
    endtask

    task automatic t_cas_bad_size;
        issue(1'b0, 48, 2, 64'h0000_0000_0000_4242, '0, 1'b0, "R2 setup for bad cas");
        issue(1'b1, 48, 2, 64'h0000_0000_0000_9999, 64'h0000_0000_0000_4242, 1'b0, "R6 cas size 2");
        issue(1'b1, 48, 1, 64'h77, 64'h42, 1'b0, "R6 cas size 1");
        issue(1'b0, 48, 2, 64'h0, '0, 1'b0, "R6 no write on bad cas");
    endtask

    task automatic t_inhibit;
        issue(1'b0, 56, 8, 64'h0F0F_0F0F_0F0F_0F0F, '0, 1'b0, "R2 inhibit setup");
        issue(1'b0, 56, 8, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b1, "R7 inhibited swap silent");
        issue(1'b1, 56, 8, 64'h0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, "R7 inhibited cas silent");
        issue(1'b0, 56, 8, 64'h0, '0, 1'b0, "R7 memory unchanged");
    endtask

    task automatic t_range;
        issue(1'b0, 256, 1, 64'h5A, '0, 1'b0, "R8 addr 256");
        issue(1'b0, 504, 8, 64'h5A, '0, 1'b0, "R8 addr 504 size 8");
        issue(1'b1, 260, 4, 64'h5A, 64'h0, 1'b0, "R8 cas out of range");
        issue(1'b0, 255, 1, 64'h00, '0, 1'b0, "R8 last byte accepted");
    endtask

    task automatic t_align;
        issue(1'b0, 4, 8, 64'h1, '0, 1'b0, "R9 misaligned 8");
        issue(1'b0, 2, 4, 64'h1, '0, 1'b0, "R9 misaligned 4");
        issue(1'b0, 64, 3, 64'h1, '0, 1'b0, "R9 size 3");
        issue(1'b0, 64, 0, 64'h1, '0, 1'b0, "R9 size 0");
        issue(1'b0, 64, 8, 64'h0, '0, 1'b0, "R9 no write from faults");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(1'b0, 72, 8, 64'hA1A1_A1A1_A1A1_A1A1, '0, 1'b0);
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_data == 64'd0, "R10 first of pair", rsp_data, 64'd0);
        drive(1'b1, 72, 8, 64'hB2B2_B2B2_B2B2_B2B2, 64'hA1A1_A1A1_A1A1_A1A1, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1 && rsp_data == 64'hA1A1_A1A1_A1A1_A1A1,
              "R10 second sees first update", rsp_data, 64'hA1A1_A1A1_A1A1_A1A1);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 silent after pair", 64'(rsp_valid), 64'd0);
        commit(72, 8, 64'hB2B2_B2B2_B2B2_B2B2);
        issue(1'b0, 72, 8, 64'h0, '0, 1'b0, "R3 back to back cas committed");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_swap_basic;
        t_little_endian;
        t_cas_full;
        t_cas_narrow;
        t_cas_bad_size;
        t_inhibit;
        t_range;
        t_align;
        t_back_to_back;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule